// File: doc/BRIEF.md
# Table-Driven Waveform Sequencer

This block is a state machine with no fixed behaviour of its own. Two loadable tables decide everything it does. The state table has up to 256 entries. Each entry names four condition bits out of a 32-bit condition vector and two boolean functions. It also names two successor states, an output byte for each successor, a 32-bit action word, a dwell count and a one-shot flag. The function table holds 32 truth tables of 16 bits each. On every evaluation step the sequencer looks up the current entry and gathers the four chosen condition bits into a 4-bit index. It reads both functions at that index and then takes the left successor, the right successor, or stays where it is.

Control logic around the sequencer fills the tables through two write ports. It then issues start, stop and invalidate commands. The alpha byte it receives from the sequencer is a set of per-transition output controls. The beta word is a set of per-state action strobes. Flags from counters, comparators, DMA and interrupts are not built here. Neighbouring logic wires them onto the condition vector: bits 0 to 15 carry control pins and bits 16 to 31 carry internal flags.

Top module: `wfsm_engine`

## Requirements
- R1: After reset, status_o reads 0 (invalid), and cur_state_o, alpha_o and beta_o all read 0.
- R2: A write to either table while status is invalid moves status to 2 (armed) at the next clock edge. A start command while invalid is ignored. An invalidate in the same cycle as the write keeps status at 0, although the write itself still lands in the table.
- R3: A start while armed puts status at 3 (running) at the next edge. On that edge cur_state_o becomes start_state_i, alpha_o becomes start_alpha_i and beta_o becomes the started entry's beta word. A start while running, or while in error, is ignored.
- R4: Commands have a fixed priority: invalidate first, then stop, then start, then normal stepping. Invalidate forces status to 0. Stop forces status to 2 from any nonzero status and leaves cur_state_o unchanged. In every status other than running, alpha_o and beta_o read 0.
- R5: The selected condition bits form the index {cond[sel_d], cond[sel_c], cond[sel_b], cond[sel_a]}, with sel_a in bit 0. A function is true when bit `index` of its 16-bit truth table is 1. For example, 0xFF00 follows d alone and 0x6666 is a XOR b.
- R6: When function f0 is true the sequencer moves to next_l and alpha_o takes alpha_l. Otherwise, when f1 is true, it moves to next_r and alpha_o takes alpha_r. When both are true, the left successor wins.
- R7: When neither function is true, cur_state_o and alpha_o keep their values.
- R8: After a state with dwell count N is entered, the next N clock edges only hold the state. Successors are evaluated at edge N+1 after entry.
- R9: beta_o shows the entry's beta word on the cycle after the state is entered. With the one-shot flag clear, it keeps showing that word for every further cycle in the state. With the flag set, it reads 0 after the first cycle.
- R10: The status becomes 7 (error) in three cases, each time with alpha_o and beta_o cleared: a transition or a start targets an entry whose valid bit is 0; or, while running, the current entry has been rewritten as invalid. In the first case cur_state_o shows the target index.
- R11: A state-table word is packed MSB first as {valid, next_l[7:0], next_r[7:0], sel_d, sel_c, sel_b, sel_a (5 bits each), f1[4:0], f0[4:0], alpha_r[7:0], alpha_l[7:0], beta[31:0], dwell[7:0], one_shot}, 104 bits in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_we | input | 1 | State table write strobe |
| st_waddr | input | 8 | State table write index |
| st_wdata | input | 104 | State table word (layout in R11) |
| fn_we | input | 1 | Function table write strobe |
| fn_waddr | input | 5 | Function table write index |
| fn_wdata | input | 16 | Truth table |
| cmd_start | input | 1 | Start command |
| start_state_i | input | 8 | State entered on start |
| start_alpha_i | input | 8 | Alpha driven on start |
| cmd_stop | input | 1 | Stop command |
| cmd_invalidate | input | 1 | Invalidate command |
| cond_i | input | 32 | Condition vector |
| status_o | output | 3 | 0 invalid, 2 armed, 3 running, 7 error |
| cur_state_o | output | 8 | Current state index |
| alpha_o | output | 8 | Transition output controls |
| beta_o | output | 32 | State action strobes |

## Verification
The functions most likely to collide are a command and a pending transition. A stop is raised in the same cycle that the current entry's condition would take the left successor. It is judged correct only if status goes to armed and cur_state_o keeps the old index. A start is paired with a stop, and a table write is paired with an invalidate. In each pair the bench expects the higher-priority action alone to show at the ports on the following cycle.

// File: rtl/wfsm_pkg.sv
package wfsm_pkg;
    localparam int ST_AW   = 8;
    localparam int NSTATES = 1 << ST_AW;
    localparam int FN_AW   = 5;
    localparam int NFUNC   = 1 << FN_AW;
    localparam int COND_W  = 32;
    localparam int SEL_W   = $clog2(COND_W);
    localparam int NSEL    = 4;
    localparam int TT_W    = 1 << NSEL;
    localparam int ALPHA_W = 8;
    localparam int BETA_W  = 32;
    localparam int REP_W   = 8;
    localparam int STAT_W  = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_INVALID = 3'd0,
        ST_ARMED   = 3'd2,
        ST_RUNNING = 3'd3,
        ST_ERROR   = 3'd7
    } eng_status_e;

    typedef logic [ST_AW-1:0] st_idx_t;

    typedef struct packed {
        logic                          valid;
        st_idx_t                       next_l;
        st_idx_t                       next_r;
        logic [NSEL-1:0][SEL_W-1:0]    sel;
        logic [FN_AW-1:0]              f1;
        logic [FN_AW-1:0]              f0;
        logic [ALPHA_W-1:0]            alpha_r;
        logic [ALPHA_W-1:0]            alpha_l;
        logic [BETA_W-1:0]             beta;
        logic [REP_W-1:0]              rep;
        logic                          beta_once;
    } st_entry_t;

    localparam int ENTRY_W = $bits(st_entry_t);
endpackage

// File: rtl/wfsm_tables.sv
module wfsm_tables
    import wfsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_we,
    input  st_idx_t            st_waddr,
    input  st_entry_t          st_wdata,
    input  logic               fn_we,
    input  logic [FN_AW-1:0]   fn_waddr,
    input  logic [TT_W-1:0]    fn_wdata,
    input  st_idx_t            cur_addr,
    output st_entry_t          cur_ent,
    input  st_idx_t            tgt_addr,
    output logic               tgt_valid,
    output logic [BETA_W-1:0]  tgt_beta,
    output logic [TT_W-1:0]    tt0,
    output logic [TT_W-1:0]    tt1
);
    st_entry_t          mem_q [NSTATES];
    logic [NSTATES-1:0] vld_q;
    logic [TT_W-1:0]    fn_q  [NFUNC];

    // Table storage carries no reset; only the per-entry valid flags do.
    always_ff @(posedge clk) begin
        if (st_we) begin
            mem_q[st_waddr] <= st_wdata;
        end
        if (fn_we) begin
            fn_q[fn_waddr] <= fn_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (st_we) begin
            vld_q[st_waddr] <= st_wdata.valid;
        end
    end

    always_comb begin
        cur_ent       = mem_q[cur_addr];
        cur_ent.valid = vld_q[cur_addr] & mem_q[cur_addr].valid;
        tgt_valid     = vld_q[tgt_addr] & mem_q[tgt_addr].valid;
        tgt_beta      = mem_q[tgt_addr].beta;
        tt0           = fn_q[cur_ent.f0];
        tt1           = fn_q[cur_ent.f1];
    end
endmodule

// File: rtl/wfsm_cond_eval.sv
module wfsm_cond_eval
    import wfsm_pkg::*;
(
    input  logic [COND_W-1:0]           cond_i,
    input  logic [NSEL-1:0][SEL_W-1:0]  sel_i,
    input  logic [TT_W-1:0]             tt0_i,
    input  logic [TT_W-1:0]             tt1_i,
    output logic                        hit0_o,
    output logic                        hit1_o
);
    logic [NSEL-1:0] pick;

    for (genvar g = 0; g < NSEL; g++) begin : g_pick
        assign pick[g] = cond_i[sel_i[g]];
    end

    // The gathered bits address one row of each truth table.
    assign hit0_o = tt0_i[pick];
    assign hit1_o = tt1_i[pick];
endmodule

// File: rtl/wfsm_seq.sv
module wfsm_seq
    import wfsm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_we,
    input  logic                cmd_start,
    input  st_idx_t             start_state_i,
    input  logic [ALPHA_W-1:0]  start_alpha_i,
    input  logic                cmd_stop,
    input  logic                cmd_invalidate,
    input  logic                cur_valid,
    input  st_idx_t             cur_next_l,
    input  st_idx_t             cur_next_r,
    input  logic [ALPHA_W-1:0]  cur_alpha_l,
    input  logic [ALPHA_W-1:0]  cur_alpha_r,
    input  logic [BETA_W-1:0]   cur_beta,
    input  logic [REP_W-1:0]    cur_rep,
    input  logic                cur_once,
    input  logic                hit0,
    input  logic                hit1,
    input  logic                tgt_valid,
    input  logic [BETA_W-1:0]   tgt_beta,
    output st_idx_t             tgt_addr,
    output logic [STAT_W-1:0]   status_o,
    output st_idx_t             cur_o,
    output logic [ALPHA_W-1:0]  alpha_o,
    output logic [BETA_W-1:0]   beta_o
);
    typedef struct packed {
        eng_status_e          status;
        st_idx_t              cur;
        logic [REP_W-1:0]     rep;
        logic [ALPHA_W-1:0]   alpha;
        logic [BETA_W-1:0]    beta;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [BETA_W-1:0] held_beta;

    function automatic seq_t enter_state(seq_t s, logic ok, logic [BETA_W-1:0] b,
                                         logic [ALPHA_W-1:0] a);
        seq_t r = s;
        r.rep = '0;
        if (ok) begin
            r.status = ST_RUNNING;
            r.alpha  = a;
            r.beta   = b;
        end else begin
            r.status = ST_ERROR;
            r.alpha  = '0;
            r.beta   = '0;
        end
        return r;
    endfunction

    assign held_beta = cur_once ? '0 : cur_beta;
    assign tgt_addr  = (seq_q.status == ST_RUNNING) ? (hit0 ? cur_next_l : cur_next_r)
                                                    : start_state_i;

    always_comb begin
        seq_d      = seq_q;
        seq_d.beta = '0;
        if (cmd_invalidate) begin
            seq_d.status = ST_INVALID;
            seq_d.alpha  = '0;
            seq_d.rep    = '0;
        end else if (cmd_stop && seq_q.status != ST_INVALID) begin
            seq_d.status = ST_ARMED;
            seq_d.alpha  = '0;
            seq_d.rep    = '0;
        end else begin
            unique case (seq_q.status)
                ST_INVALID: begin
                    if (tbl_we) begin
                        seq_d.status = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (cmd_start) begin
                        seq_d.cur = start_state_i;
                        seq_d     = enter_state(seq_d, tgt_valid, tgt_beta, start_alpha_i);
                    end
                end
                ST_RUNNING: begin
                    if (!cur_valid) begin
                        seq_d.status = ST_ERROR;
                        seq_d.alpha  = '0;
                        seq_d.rep    = '0;
                    end else if (seq_q.rep < cur_rep) begin
                        seq_d.rep  = seq_q.rep + REP_W'(1);
                        seq_d.beta = held_beta;
                    end else if (hit0) begin
                        seq_d.cur = cur_next_l;
                        seq_d     = enter_state(seq_d, tgt_valid, tgt_beta, cur_alpha_l);
                    end else if (hit1) begin
                        seq_d.cur = cur_next_r;
                        seq_d     = enter_state(seq_d, tgt_valid, tgt_beta, cur_alpha_r);
                    end else begin
                        seq_d.beta = held_beta;
                    end
                end
                default: begin
                    seq_d.alpha = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{status: ST_INVALID, cur: '0, rep: '0, alpha: '0, beta: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign status_o = seq_q.status;
    assign cur_o    = seq_q.cur;
    assign alpha_o  = seq_q.alpha;
    assign beta_o   = seq_q.beta;
endmodule

// File: rtl/wfsm_engine.sv
module wfsm_engine
    import wfsm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_we,
    input  logic [ST_AW-1:0]    st_waddr,
    input  logic [ENTRY_W-1:0]  st_wdata,
    input  logic                fn_we,
    input  logic [FN_AW-1:0]    fn_waddr,
    input  logic [TT_W-1:0]     fn_wdata,
    input  logic                cmd_start,
    input  logic [ST_AW-1:0]    start_state_i,
    input  logic [ALPHA_W-1:0]  start_alpha_i,
    input  logic                cmd_stop,
    input  logic                cmd_invalidate,
    input  logic [COND_W-1:0]   cond_i,
    output logic [STAT_W-1:0]   status_o,
    output logic [ST_AW-1:0]    cur_state_o,
    output logic [ALPHA_W-1:0]  alpha_o,
    output logic [BETA_W-1:0]   beta_o
);
    st_entry_t          cur_ent;
    st_idx_t            tgt_addr;
    logic               tgt_valid;
    logic [BETA_W-1:0]  tgt_beta;
    logic [TT_W-1:0]    tt0, tt1;
    logic               hit0, hit1;

    wfsm_tables tables_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_we     (st_we),
        .st_waddr  (st_waddr),
        .st_wdata  (st_entry_t'(st_wdata)),
        .fn_we     (fn_we),
        .fn_waddr  (fn_waddr),
        .fn_wdata  (fn_wdata),
        .cur_addr  (cur_state_o),
        .cur_ent   (cur_ent),
        .tgt_addr  (tgt_addr),
        .tgt_valid (tgt_valid),
        .tgt_beta  (tgt_beta),
        .tt0       (tt0),
        .tt1       (tt1)
    );

    wfsm_cond_eval eval_i (
        .cond_i (cond_i),
        .sel_i  (cur_ent.sel),
        .tt0_i  (tt0),
        .tt1_i  (tt1),
        .hit0_o (hit0),
        .hit1_o (hit1)
    );

    wfsm_seq seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tbl_we         (st_we | fn_we),
        .cmd_start      (cmd_start),
        .start_state_i  (start_state_i),
        .start_alpha_i  (start_alpha_i),
        .cmd_stop       (cmd_stop),
        .cmd_invalidate (cmd_invalidate),
        .cur_valid      (cur_ent.valid),
        .cur_next_l     (cur_ent.next_l),
        .cur_next_r     (cur_ent.next_r),
        .cur_alpha_l    (cur_ent.alpha_l),
        .cur_alpha_r    (cur_ent.alpha_r),
        .cur_beta       (cur_ent.beta),
        .cur_rep        (cur_ent.rep),
        .cur_once       (cur_ent.beta_once),
        .hit0           (hit0),
        .hit1           (hit1),
        .tgt_valid      (tgt_valid),
        .tgt_beta       (tgt_beta),
        .tgt_addr       (tgt_addr),
        .status_o       (status_o),
        .cur_o          (cur_state_o),
        .alpha_o        (alpha_o),
        .beta_o         (beta_o)
    );
endmodule

// File: rtl/wfsm_engine_chk.sv
module wfsm_engine_chk
    import wfsm_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                st_we,
    input logic                fn_we,
    input logic                cmd_start,
    input logic [ST_AW-1:0]    start_state_i,
    input logic [ALPHA_W-1:0]  start_alpha_i,
    input logic                cmd_stop,
    input logic                cmd_invalidate,
    input logic [STAT_W-1:0]   status_o,
    input logic [ST_AW-1:0]    cur_state_o,
    input logic [ALPHA_W-1:0]  alpha_o,
    input logic [BETA_W-1:0]   beta_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != ST_RUNNING |-> (alpha_o == '0 && beta_o == '0)); // R4

    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_INVALID || status_o == ST_ARMED ||
         status_o == ST_RUNNING || status_o == ST_ERROR)); // R1

    AST_INVALIDATE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_invalidate |=> status_o == ST_INVALID); // R4

    AST_STOP_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_invalidate && status_o != ST_INVALID) |=> status_o == ST_ARMED); // R4

    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_INVALID && (st_we || fn_we) && !cmd_invalidate) |=> status_o == ST_ARMED); // R2

    AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_INVALID && !st_we && !fn_we) |=> status_o == ST_INVALID); // R2

    AST_START_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == ST_ARMED && cmd_start && !cmd_stop && !cmd_invalidate)
        |=> ((status_o == ST_RUNNING && alpha_o == $past(start_alpha_i)) || status_o == ST_ERROR)
            && cur_state_o == $past(start_state_i)); // R3
endmodule

bind wfsm_engine wfsm_engine_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .st_we          (st_we),
    .fn_we          (fn_we),
    .cmd_start      (cmd_start),
    .start_state_i  (start_state_i),
    .start_alpha_i  (start_alpha_i),
    .cmd_stop       (cmd_stop),
    .cmd_invalidate (cmd_invalidate),
    .status_o       (status_o),
    .cur_state_o    (cur_state_o),
    .alpha_o        (alpha_o),
    .beta_o         (beta_o)
);

// File: tb/wfsm_engine_tb_top.sv
`timescale 1ns/1ps
module wfsm_engine_tb_top;
    import wfsm_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n;
    logic                st_we, fn_we, cmd_start, cmd_stop, cmd_invalidate;
    logic [ST_AW-1:0]    st_waddr, start_state_i;
    logic [ENTRY_W-1:0]  st_wdata;
    logic [FN_AW-1:0]    fn_waddr;
    logic [TT_W-1:0]     fn_wdata;
    logic [ALPHA_W-1:0]  start_alpha_i;
    logic [COND_W-1:0]   cond_i;
    logic [STAT_W-1:0]   status_o;
    logic [ST_AW-1:0]    cur_state_o;
    logic [ALPHA_W-1:0]  alpha_o;
    logic [BETA_W-1:0]   beta_o;

    wfsm_engine dut_i (.*);

    typedef struct packed {
        logic [STAT_W-1:0]  st;
        logic [ST_AW-1:0]   cur;
        logic [ALPHA_W-1:0] al;
        logic [BETA_W-1:0]  be;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    // Scoreboard model state, built from the written requirements
    st_entry_t          m_ent [NSTATES];
    bit                 m_vld [NSTATES];
    logic [TT_W-1:0]    m_fn  [NFUNC];
    logic [STAT_W-1:0]  m_st  = 3'd0;
    logic [ST_AW-1:0]   m_cur = '0;
    logic [REP_W-1:0]   m_rep = '0;
    logic [ALPHA_W-1:0] m_al  = '0;
    logic [BETA_W-1:0]  m_be  = '0;

    function automatic obs_t now_obs();
        return {status_o, cur_state_o, alpha_o, beta_o};
    endfunction

    task automatic compare(obs_t got, obs_t exp, string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s st/cur/alpha/beta got %0h/%0h/%0h/%0h exp %0h/%0h/%0h/%0h",
                     tag, got.st, got.cur, got.al, got.be, exp.st, exp.cur, exp.al, exp.be);
        end
    endtask

    // Monitor: compares once per cycle, away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                obs_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compare(now_obs(), e, t);
            end
        end
    end

    function automatic st_entry_t mk(bit v, int nl, int nr, int sa, int sb, int sc, int sd,
                                     int f0, int f1, int al, int ar, logic [31:0] be,
                                     int rep, bit once);
        st_entry_t r;
        r.valid = v;           r.next_l = ST_AWidx(nl); r.next_r = ST_AWidx(nr);
        r.sel[0] = SEL_W'(sa); r.sel[1] = SEL_W'(sb);
        r.sel[2] = SEL_W'(sc); r.sel[3] = SEL_W'(sd);
        r.f0 = FN_AW'(f0);     r.f1 = FN_AW'(f1);
        r.alpha_l = ALPHA_W'(al); r.alpha_r = ALPHA_W'(ar);
        r.beta = be;           r.rep = REP_W'(rep); r.beta_once = once;
        return r;
    endfunction

    function automatic logic [ST_AW-1:0] ST_AWidx(int v);
        return ST_AW'(v);
    endfunction

    task automatic model_step();
        logic [STAT_W-1:0]  s  = m_st;
        logic [ST_AW-1:0]   cu = m_cur;
        logic [REP_W-1:0]   rp = m_rep;
        logic [ALPHA_W-1:0] al = m_al;
        logic [BETA_W-1:0]  be = '0;
        st_entry_t          e;
        logic [3:0]         idx;
        bit                 go = 0;
        logic [ST_AW-1:0]   t  = '0;
        logic [ALPHA_W-1:0] ta = '0;
        e = m_ent[m_cur];
        if (cmd_invalidate) begin
            s = 3'd0; al = '0; rp = '0;
        end else if (cmd_stop && m_st != 3'd0) begin
            s = 3'd2; al = '0; rp = '0;
        end else if (m_st == 3'd0) begin
            if (st_we || fn_we) s = 3'd2;
        end else if (m_st == 3'd2) begin
            if (cmd_start) begin go = 1; t = start_state_i; ta = start_alpha_i; end
        end else if (m_st == 3'd3) begin
            if (!m_vld[m_cur]) begin
                s = 3'd7; al = '0; rp = '0;
            end else if (m_rep < e.rep) begin
                rp = m_rep + 1'b1;
                be = e.beta_once ? '0 : e.beta;
            end else begin
                idx = {cond_i[e.sel[3]], cond_i[e.sel[2]], cond_i[e.sel[1]], cond_i[e.sel[0]]};
                if (m_fn[e.f0][idx]) begin go = 1; t = e.next_l; ta = e.alpha_l; end
                else if (m_fn[e.f1][idx]) begin go = 1; t = e.next_r; ta = e.alpha_r; end
                else be = e.beta_once ? '0 : e.beta;
            end
        end
        if (go) begin
            cu = t; rp = '0;
            if (m_vld[t]) begin s = 3'd3; al = ta; be = m_ent[t].beta; end
            else begin s = 3'd7; al = '0; be = '0; end
        end
        m_st = s; m_cur = cu; m_rep = rp; m_al = al; m_be = be;
        if (st_we) begin
            m_ent[st_waddr] = st_entry_t'(st_wdata);
            m_vld[st_waddr] = st_wdata[ENTRY_W-1];
        end
        if (fn_we) m_fn[fn_waddr] = fn_wdata;
    endtask

    // Driver: one clock cycle, pushing the expected observation
    task automatic cyc(string tag);
        model_step();
        exp_q.push_back({m_st, m_cur, m_al, m_be});
        tag_q.push_back(tag);
        @(negedge clk);
        st_we = 0; fn_we = 0; cmd_start = 0; cmd_stop = 0; cmd_invalidate = 0;
    endtask

    task automatic wr_fn(int i, logic [15:0] tt, string tag);
        fn_we = 1; fn_waddr = FN_AW'(i); fn_wdata = tt;
        cyc(tag);
    endtask

    task automatic wr_st(int i, st_entry_t e, string tag);
        st_we = 1; st_waddr = ST_AW'(i); st_wdata = e;
        cyc(tag);
    endtask

    task automatic start(int s, int a, string tag);
        cmd_start = 1; start_state_i = ST_AW'(s); start_alpha_i = ALPHA_W'(a);
        cyc(tag);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog expired got running exp finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSTATES; i++) m_vld[i] = 0;
        rst_n = 0; st_we = 0; fn_we = 0; cmd_start = 0; cmd_stop = 0; cmd_invalidate = 0;
        st_waddr = '0; st_wdata = '0; fn_waddr = '0; fn_wdata = '0;
        start_state_i = '0; start_alpha_i = '0; cond_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare(now_obs(), '0, "R1 reset state");

        start(0, 5, "R2 start ignored while invalid");
        fn_we = 1; fn_waddr = 0; fn_wdata = 16'hAAAA; cmd_invalidate = 1;
        cyc("R2 invalidate beats arming write");
        wr_fn(0, 16'hAAAA, "R2 write arms");
        wr_fn(1, 16'hCCCC, "R5 table load");
        wr_fn(2, 16'hF0F0, "R5 table load");
        wr_fn(3, 16'hFF00, "R5 table load");
        wr_fn(4, 16'h0000, "R5 table load");
        wr_fn(5, 16'hFFFF, "R5 table load");
        wr_fn(6, 16'h8000, "R5 table load");
        wr_fn(7, 16'h6666, "R5 table load");
        wr_st(0, mk(1, 1, 2, 3, 17, 30, 31, 0, 1, 'h11, 'h22, 32'h1000_0001, 0, 0), "R11 load");
        wr_st(1, mk(1, 0, 0, 0, 1, 2, 3, 6, 4, 'h33, 'h00, 32'h0000_00F0, 2, 1), "R11 load");
        wr_st(2, mk(1, 0, 3, 5, 6, 0, 0, 4, 7, 'h00, 'h44, 32'h0000_0F00, 0, 0), "R11 load");
        wr_st(4, mk(1, 5, 6, 0, 0, 0, 0, 5, 5, 'h55, 'h66, 32'h0000_0005, 0, 0), "R11 load");
        wr_st(5, mk(1, 0, 0, 0, 0, 0, 0, 4, 4, 'h00, 'h00, 32'hAAAA_0000, 0, 0), "R11 load");
        wr_st(6, mk(1, 0, 4, 0, 0, 16, 31, 3, 2, 'h77, 'h88, 32'h0000_6000, 0, 0), "R11 load");

        start(0, 'h0F, "R3 R11 start enters state");
        cond_i = '0;
        cyc("R7 no function true stays");
        cyc("R9 beta held without one-shot");
        start(5, 1, "R3 start ignored while running");
        cond_i = (32'h1 << 3) | (32'h1 << 17);
        cyc("R6 both true takes left");
        cond_i = '1;
        cyc("R8 dwell first cycle R9 one-shot clears");
        cyc("R8 dwell second cycle");
        cyc("R8 evaluates after dwell");
        cond_i = 32'h1 << 17;
        cyc("R6 f1 alone takes right");
        cond_i = (32'h1 << 5) | (32'h1 << 6);
        cyc("R5 xor false stays");
        cond_i = 32'h1 << 5;
        cyc("R10 transition into invalid entry");
        start(0, 1, "R10 start ignored in error");
        cmd_stop = 1; cyc("R4 stop from error");
        start(3, 9, "R10 start into invalid entry");
        cmd_stop = 1; cyc("R4 stop");
        start(4, 0, "R3 start");
        cond_i = '0;
        cyc("R6 left priority when both true");
        cyc("R7 stays");
        wr_st(5, mk(0, 0, 0, 0, 0, 0, 0, 4, 4, 0, 0, 32'h0, 0, 0), "R10 rewrite running entry");
        cyc("R10 current entry invalid");
        cmd_stop = 1; cmd_invalidate = 1; cyc("R4 invalidate beats stop");
        wr_st(5, mk(1, 0, 0, 0, 0, 0, 0, 4, 4, 0, 0, 32'hAAAA_0000, 0, 0), "R2 write arms");
        cmd_start = 1; start_state_i = 5; start_alpha_i = 3; cmd_stop = 1;
        cyc("R4 stop beats start");
        start(0, 1, "R3 start");
        cond_i = 32'h1 << 3; cmd_stop = 1;
        cyc("R4 stop beats transition");
        start(6, 2, "R3 start");
        cond_i = 32'h1 << 31;
        cyc("R5 top condition index");
        cmd_stop = 1; cyc("R4 stop");
        start(6, 2, "R3 start");
        cond_i = 32'h1 << 16;
        cyc("R5 third selector right");
        cmd_invalidate = 1; cyc("R4 invalidate");

        repeat (2) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end
endmodule